// File: doc/BRIEF.md
# Buffered UART Transmit Engine

This block is the send side of a classic asynchronous serial port. A producer hands bytes in over a valid/ready stream. The bytes go into a store that acts either as a single holding register or as a 64-entry first-in first-out buffer, depending on a runtime mode pin. A shift engine takes each byte out of the store and turns it into a frame on the serial line: a low start bit, 5 to 8 data bits sent least significant bit first, an optional even or odd parity bit, and one or two high stop bits.

Bit timing comes from an oversampling tick input, which is generated outside the block. One bit lasts 16 ticks, or 8 ticks when the fast-oversampling pin is high. Word length, parity, stop length and oversampling rate are captured when each frame's byte is loaded, so they can be changed while a frame is being sent without corrupting it. Status pins report when the store is empty, when the whole transmitter is empty, and a transmit-empty interrupt that is gated by an enable pin.

The stream back-pressure rules are as follows. A byte is taken on any clock where `in_valid` and `in_ready` are both high. `in_ready` depends only on the current fill level and on `fifo_en`. A producer may hold `in_valid` with the same byte until it is taken. In every cycle where `in_valid` is high and `in_ready` is low, nothing is stored and `overflow` is high.

Top module: `uart_tx_engine`

## Requirements
- R1: After reset, `txd`=1, `thr_empty`=1, `tx_empty`=1, `tx_irq`=0 and `in_ready`=1.
- R2: A frame is a start bit at 0, then the data bits with bit 0 first, then the parity bit if `par_en`=1, then the stop bits at 1. When another byte is waiting as the last stop bit ends, its start bit follows with no idle time between the frames.
- R3: Every bit lasts 16 `os_tick` pulses when `os_8x`=0, or 8 pulses when `os_8x`=1. The value of `os_8x` is captured when the frame's byte is loaded.
- R4: `wlen` selects the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. It is captured when the byte is loaded.
- R5: With `par_odd`=0, the data bits plus the parity bit hold an even number of ones. With `par_odd`=1, they hold an odd number.
- R6: `two_stop`=0 sends one stop bit and `two_stop`=1 sends two.
- R7: With `fifo_en`=1, the store holds up to 64 bytes and sends them in the order they were written. `in_ready` is 0 only while 64 bytes are stored.
- R8: With `fifo_en`=0, the store holds one byte. `in_ready` is 0 while that byte is present. The mode can change at any time, and bytes already stored are still sent.
- R9: In a cycle with `in_valid`=1 and `in_ready`=0, `overflow` is 1 and the byte is dropped.
- R10: `thr_empty` is 1 exactly when the store is empty. It rises in the cycle after the last stored byte moves into the shift register.
- R11: `tx_empty` is 1 only when the store is empty and no frame, including its stop bits, is in progress. `txd` is 1 whenever `tx_empty` is 1.
- R12: `tx_irq` equals `thr_empty` when `irq_en`=1, and is 0 when `irq_en`=0.
- R13: When the line is idle and a byte is stored, the byte is loaded on the next clock, and `txd` goes low one cycle later. A bit that is in progress changes only on a clock where `os_tick`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| os_tick | input | 1 | Oversampling tick, one clock wide |
| os_8x | input | 1 | 1: 8 ticks per bit, 0: 16 ticks per bit |
| fifo_en | input | 1 | 1: 64-byte buffer, 0: single holding register |
| wlen | input | 2 | Data bits minus 5 |
| par_en | input | 1 | Send a parity bit |
| par_odd | input | 1 | 1: odd parity, 0: even parity |
| two_stop | input | 1 | 1: two stop bits |
| irq_en | input | 1 | Transmit-empty interrupt enable |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Store can take a byte |
| overflow | output | 1 | Write attempted while not ready |
| txd | output | 1 | Serial line, idles at 1 |
| thr_empty | output | 1 | Store empty |
| tx_empty | output | 1 | Store and shifter both empty |
| tx_irq | output | 1 | Gated transmit-empty interrupt |

## Verification
A wrong fill count shows up at `in_ready` and `thr_empty` in the next cycle. It also appears as a missing, repeated or reordered character on `txd` as soon as the affected byte is sent. A broken tick counter or a wrong captured setting shows up within a single bit time, as an edge on `txd` one tick early or late, or as an extra or missing bit. A wrong idle or interrupt decode shows up on `tx_empty` or `tx_irq` in the cycle after the last stop bit ends. A cycle-level model compares every output pin on every clock, so any such slip is caught in the cycle where it first reaches a port.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int BYTE_W   = 8;
  localparam int MIN_WORD = 5;

  typedef enum logic [2:0] {
    TX_IDLE,
    TX_START,
    TX_DATA,
    TX_PAR,
    TX_STOP
  } tx_state_e;

  typedef struct packed {
    logic [1:0] wlen;
    logic       par_en;
    logic       par_odd;
    logic       two_stop;
    logic       os8;
  } frame_cfg_t;
endpackage

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_one,
  input  logic         push_valid,
  input  logic [W-1:0] push_data,
  output logic         push_ready,
  input  logic         pop,
  output logic [W-1:0] pop_data,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;
  logic          do_push, do_pop;

  assign limit      = cap_one ? CW'(1) : CW'(DEPTH);
  assign push_ready = (cnt < limit);
  assign empty      = (cnt == '0);
  assign do_push    = push_valid && push_ready;
  assign do_pop     = pop && !empty;
  assign pop_data   = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/uart_tx_bitclk.sv
module uart_tx_bitclk #(
  parameter int OS_HI = 16,
  parameter int OS_LO = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic os_tick,
  input  logic os8,
  output logic bit_done
);
  localparam int CW = $clog2(OS_HI);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign lim      = os8 ? CW'(OS_LO - 1) : CW'(OS_HI - 1);
  assign bit_done = os_tick && (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (restart)  cnt <= '0;
    else if (bit_done) cnt <= '0;
    else if (os_tick)  cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
  import uart_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  frame_cfg_t        cfg_in,
  input  logic              avail,
  input  logic [BYTE_W-1:0] data,
  input  logic              bit_done,
  output logic              load,
  output logic              txd,
  output logic              idle,
  output logic              cur_os8
);
  tx_state_e         state;
  frame_cfg_t        cfg;
  logic [BYTE_W-1:0] shreg;
  logic [2:0]        bit_idx;
  logic              stop_idx;
  logic              par_bit;
  logic              par_calc;
  logic              stop_last;
  logic              data_last;

  assign stop_last = (stop_idx == cfg.two_stop);
  assign data_last = (bit_idx == (3'(cfg.wlen) + 3'(MIN_WORD - 1)));
  assign load      = avail && ((state == TX_IDLE) ||
                               ((state == TX_STOP) && bit_done && stop_last));
  assign idle      = (state == TX_IDLE);
  assign cur_os8   = cfg.os8;

  always_comb begin
    par_calc = cfg_in.par_odd;
    for (int i = 0; i < BYTE_W; i++) begin
      if (i < MIN_WORD + int'(cfg_in.wlen)) par_calc = par_calc ^ data[i];
    end
  end

  always_comb begin
    case (state)
      TX_START: txd = 1'b0;
      TX_DATA:  txd = shreg[0];
      TX_PAR:   txd = par_bit;
      default:  txd = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= TX_IDLE;
      cfg      <= '0;
      shreg    <= '0;
      bit_idx  <= '0;
      stop_idx <= 1'b0;
      par_bit  <= 1'b0;
    end else if (load) begin
      state    <= TX_START;
      cfg      <= cfg_in;
      shreg    <= data;
      bit_idx  <= '0;
      stop_idx <= 1'b0;
      par_bit  <= par_calc;
    end else if (bit_done) begin
      case (state)
        TX_START: state <= TX_DATA;
        TX_DATA: begin
          shreg <= shreg >> 1;
          if (data_last) state <= cfg.par_en ? TX_PAR : TX_STOP;
          else           bit_idx <= bit_idx + 3'd1;
        end
        TX_PAR: state <= TX_STOP;
        TX_STOP: begin
          if (stop_last) state <= TX_IDLE;
          else           stop_idx <= 1'b1;
        end
        default: state <= TX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_tx_engine.sv
module uart_tx_engine
  import uart_tx_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int OS_HI = 16,
  parameter int OS_LO = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       os_tick,
  input  logic       os_8x,
  input  logic       fifo_en,
  input  logic [1:0] wlen,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       two_stop,
  input  logic       irq_en,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  output logic       overflow,
  output logic       txd,
  output logic       thr_empty,
  output logic       tx_empty,
  output logic       tx_irq
);
  frame_cfg_t        cfg_now;
  logic              load, idle, bit_done, cur_os8;
  logic [BYTE_W-1:0] head;

  assign cfg_now = '{wlen: wlen, par_en: par_en, par_odd: par_odd,
                     two_stop: two_stop, os8: os_8x};

  uart_tx_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) u_store (
    .clk(clk), .rst_n(rst_n), .cap_one(!fifo_en),
    .push_valid(in_valid), .push_data(in_data), .push_ready(in_ready),
    .pop(load), .pop_data(head), .empty(thr_empty)
  );

  uart_tx_bitclk #(.OS_HI(OS_HI), .OS_LO(OS_LO)) u_bitclk (
    .clk(clk), .rst_n(rst_n), .restart(load), .os_tick(os_tick),
    .os8(cur_os8), .bit_done(bit_done)
  );

  uart_tx_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .cfg_in(cfg_now), .avail(!thr_empty),
    .data(head), .bit_done(bit_done), .load(load), .txd(txd),
    .idle(idle), .cur_os8(cur_os8)
  );

  assign overflow = in_valid && !in_ready;
  assign tx_empty = thr_empty && idle;
  assign tx_irq   = thr_empty && irq_en;
endmodule

// File: rtl/uart_tx_engine_chk.sv
module uart_tx_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic os_tick,
  input logic fifo_en,
  input logic in_valid,
  input logic in_ready,
  input logic overflow,
  input logic txd,
  input logic thr_empty,
  input logic tx_empty,
  input logic tx_irq,
  input logic irq_en
);
  a_r9_overflow_cause: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> (in_valid && !in_ready));
  a_r11_idle_means_store_empty: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> thr_empty);
  a_r11_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> txd);
  a_r8_single_slot_full: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && !thr_empty) |-> !in_ready);
  a_r7_room_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    thr_empty |-> in_ready);
  a_r12_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !tx_irq);
  a_r13_low_bit_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!txd && !os_tick) |=> !txd);
endmodule

bind uart_tx_engine uart_tx_engine_chk u_chk (.*);

// File: tb/sim_uart_tx_engine.sv
`timescale 1ns/1ps
module sim_uart_tx_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic os_tick = 1'b0, os_8x = 1'b0, fifo_en = 1'b1;
  logic [1:0] wlen = 2'd3;
  logic par_en = 1'b0, par_odd = 1'b0, two_stop = 1'b0, irq_en = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready, overflow, txd, thr_empty, tx_empty, tx_irq;

  int checks = 0, errors = 0, cycles = 0, tick_per = 1, tcount = 0;
  bit done = 0;

  always #4 clk = ~clk;

  uart_tx_engine u0 (.*);

  // oversampling tick source
  always @(posedge clk) begin
    #1;
    if (tick_per == 0) os_tick = 1'b0;
    else begin
      tcount = tcount + 1;
      if (tcount >= tick_per) tcount = 0;
      os_tick = (tcount == 0);
    end
  end

  // behavioural reference model
  int  q[$];
  bit  bits[$];
  int  mt = 0, nper = 16;
  bit  busy = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); bits.delete(); busy = 0; mt = 0;
    end else begin
      automatic bit acc = in_valid && (q.size() < (fifo_en ? 64 : 1));
      if (busy && os_tick) begin
        if (mt == nper - 1) begin
          mt = 0;
          void'(bits.pop_front());
          if (bits.size() == 0) busy = 0;
        end else mt++;
      end
      if (!busy && q.size() > 0) begin
        automatic int d = q.pop_front();
        automatic int n = 5 + int'(wlen);
        automatic int ones = 0;
        bits.push_back(1'b0);
        for (int i = 0; i < n; i++) begin
          bits.push_back(d[i]);
          ones += d[i];
        end
        if (par_en) bits.push_back(((ones % 2) == 1) ^ par_odd);
        bits.push_back(1'b1);
        if (two_stop) bits.push_back(1'b1);
        nper = os_8x ? 8 : 16;
        mt = 0;
        busy = 1;
      end
      if (acc) q.push_back(int'(in_data));
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      automatic bit e_ready = q.size() < (fifo_en ? 64 : 1);
      automatic bit e_txd = busy ? bits[0] : 1'b1;
      automatic bit e_thr = (q.size() == 0);
      chk(txd == e_txd, "txd R2 R3 R4 R5 R6 R13", txd, e_txd);
      chk(in_ready == e_ready, "in_ready R7 R8", in_ready, e_ready);
      chk(overflow == (in_valid && !e_ready), "overflow R9", overflow, in_valid && !e_ready);
      chk(thr_empty == e_thr, "thr_empty R10", thr_empty, e_thr);
      chk(tx_empty == (e_thr && !busy), "tx_empty R11", tx_empty, e_thr && !busy);
      chk(tx_irq == (e_thr && irq_en), "tx_irq R12", tx_irq, e_thr && irq_en);
    end
  end

  task automatic send(input logic [7:0] b);
    in_valid = 1'b1; in_data = b;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    forever begin
      @(negedge clk);
      if (tx_empty && !in_valid) break;
    end
    @(posedge clk); #1;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      chk(1'b0, "watchdog", cycles, 150000);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(txd == 1'b1, "R1 txd", txd, 1);
    chk(thr_empty && tx_empty, "R1 empties", {thr_empty, tx_empty}, 3);
    chk(in_ready == 1'b1 && tx_irq == 1'b0, "R1 ready/irq", {in_ready, tx_irq}, 2);
    @(posedge clk); #1;

    // 8N1 16x back-to-back (R2, R3)
    send(8'hA5); send(8'h3C);
    wait_idle();
    // 7 bits even parity (R4, R5)
    wlen = 2'd2; par_en = 1'b1; par_odd = 1'b0;
    send(8'h5B); send(8'h7F);
    wait_idle();
    // 5 bits odd parity two stops, 8x (R3, R6)
    wlen = 2'd0; par_odd = 1'b1; two_stop = 1'b1; os_8x = 1'b1;
    send(8'h13); send(8'h00);
    wait_idle();
    // 6 bits, no parity, settings changed mid-frame (captured at load)
    wlen = 2'd1; par_en = 1'b0; two_stop = 1'b0; tick_per = 2;
    send(8'h2A);
    repeat (20) @(posedge clk);
    #1 os_8x = 1'b0; wlen = 2'd3;
    send(8'hC3);
    wait_idle();

    // R7 fill the buffer with ticks halted, then R9 overflow
    tick_per = 0; irq_en = 1'b1;
    for (int i = 0; i < 65; i++) send(8'(i * 7 + 1));
    @(negedge clk);
    chk(in_ready == 1'b0, "R7 full after 64 stored", in_ready, 0);
    @(posedge clk); #1;
    in_valid = 1'b1; in_data = 8'hEE;
    @(negedge clk);
    chk(overflow == 1'b1, "R9 overflow raised", overflow, 1);
    @(posedge clk); #1;
    in_valid = 1'b0;
    tick_per = 1;
    wait_idle();

    // R8 single register mode, R10 thr_empty after transfer
    fifo_en = 1'b0; tick_per = 0;
    send(8'h81);
    send(8'h42);
    @(negedge clk);
    chk(in_ready == 1'b0, "R8 one byte held", in_ready, 0);
    chk(thr_empty == 1'b0, "R10 held byte", thr_empty, 0);
    @(posedge clk); #1;
    tick_per = 1;
    send(8'h99);
    wait_idle();

    // R8 runtime mode switch with bytes stored
    fifo_en = 1'b1; tick_per = 0;
    send(8'h11); send(8'h22); send(8'h33);
    fifo_en = 1'b0;
    @(negedge clk);
    chk(in_ready == 1'b0, "R8 switch keeps bytes", in_ready, 0);
    @(posedge clk); #1;
    irq_en = 1'b0; tick_per = 3;
    wait_idle();
    @(negedge clk);
    chk(tx_empty && txd, "R11 final idle", {tx_empty, txd}, 3);
    chk(tx_irq == 1'b0, "R12 masked irq", tx_irq, 0);
    finish_run();
  end
endmodule